// File: doc/BRIEF.md
# Video Processor Host Port Controller

This block is the processor-facing side of a tile-based video processor. A host CPU reaches it through two byte-wide ports, a data port and a control port. Each port has its own read and write strobe. Two-byte command words go through the control port and set a 14-bit access address and an access mode. The data port then streams bytes into video RAM or palette RAM, or reads video RAM back through a one-byte read-ahead buffer. The same command path loads eleven 8-bit mode registers. Reading the control port returns a status byte with sticky event flags.

The block also keeps the scanline interrupt logic. The renderer gives it a line-advance pulse together with the number of the line that is ending. It also gives it pulses for sprite overflow and sprite collision. From these the block drives an active-low interrupt line. The renderer reads palette entries through a combinational lookup port and sees all mode registers on a flat output bus.

Video RAM storage is a synchronous array with a parameterised depth (4096 bytes by default). The 14-bit address space mirrors onto it. Results of host strobes are visible in the cycle after the strobe edge. Strobes must be spaced at least two clock cycles apart so that a buffer refill finishes before the next access.

Top module: `vdpHostPort`

## Requirements
- R1: The control port takes two-byte words tracked by a write toggle. The first byte replaces address bits 7:0 at once. In the second byte, bits 7:6 give the command and bits 5:0 give address bits 13:8. Commands are 00 read setup, 01 video RAM write, 10 register write and 11 palette write.
- R2: Command 00 fetches the byte at the new address into the read buffer and leaves the address one higher. A data port read returns the buffered byte and then refills the buffer from the current address.
- R3: A data port write under command 11 stores into palette entry (address AND 0x1F) and also replaces the read buffer with the written byte. Under any other command it stores into video RAM. palData shows the palette entry at palIdx.
- R4: The address increments after every data port read or write and wraps from 0x3FFF to 0x0000.
- R5: Command 10 writes the first byte into the mode register numbered by bits 3:0 of the second byte. Register numbers 11 to 15 change nothing. Register n appears on modeRegs[8n+7:8n].
- R6: The write toggle returns to the first-byte state after a second byte, a status read, a data read or a data write.
- R7: A status read returns frame pending in bit 7, sprite overflow in bit 6, sprite collision in bit 5 and zeros in bits 4:0. All three flags are sticky, and one read clears all of them. The reset state reads 0x00.
- R8: A line-advance pulse for line 192 sets frame pending.
- R9: For lines 0 to 192 the line counter decrements on each line-advance pulse. On a step from 0x00 it reloads from register 10 and, if register 0 bit 4 is set, latches a line interrupt. Pulses for all other lines reload the counter.
- R10: Writing register 10 changes only the reload value, never the running count.
- R11: intN is low while frame pending is set with register 1 bit 5, or while a line interrupt is latched. The line interrupt is not visible in the status byte, and a status read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWr | input | 1 | Control port write strobe |
| ctrlRd | input | 1 | Control port (status) read strobe |
| dataWr | input | 1 | Data port write strobe |
| dataRd | input | 1 | Data port read strobe |
| wrData | input | 8 | Byte written by the host |
| rdData | output | 8 | Byte returned to the host during a read strobe |
| lineTick | input | 1 | One-cycle pulse at the end of a scanline |
| lineNum | input | 9 | Number of the line that is ending |
| sprOvf | input | 1 | Sprite overflow event pulse |
| sprCol | input | 1 | Sprite collision event pulse |
| palIdx | input | 5 | Renderer palette lookup index |
| palData | output | 8 | Palette entry at palIdx |
| modeRegs | output | 88 | All mode registers, register n at bits 8n+7:8n |
| intN | output | 1 | Active-low interrupt request |

## Verification
The bench writes a lone first control byte between data writes. A design that waits for the second byte before moving the low address bits would put the data at the old location. It reads back across the 0x3FFF boundary, where a missing wrap or a stale prefetch returns the wrong byte. It also checks that the first read after a palette write gives the written value. Line-counter scenes hit line 192, where both interrupt sources fire together, and line 193, which must reload rather than count. They also rewrite register 10 in the middle of a count, which would move the interrupt by a line if the write reached the running counter. A status read placed between two control bytes shows whether the toggle really resets.

// File: rtl/hpPkg.sv
package hpPkg;
  typedef enum logic [1:0] {
    CMD_VRD = 2'b00,
    CMD_VWR = 2'b01,
    CMD_REG = 2'b10,
    CMD_PAL = 2'b11
  } hostCmdE;

  // Per-cycle strobes issued by the control unit to the datapath.
  typedef struct packed {
    logic loadLow;   // first control byte: low address bits
    logic loadHigh;  // second control byte: high address bits
    logic prefetch;  // read setup fetch into buffer
    logic regWr;     // mode register write
    logic ramRd;     // data port read: refill buffer
    logic ramWr;     // data port write into video RAM
    logic palWr;     // data port write into palette RAM
    logic dataAdv;   // address increment after data access
    logic statusRd;  // status read: clear sticky flags
  } hostStrobeS;
endpackage

// File: rtl/hpCtrl.sv
module hpCtrl
  import hpPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWr,
  input  logic       ctrlRd,
  input  logic       dataWr,
  input  logic       dataRd,
  input  logic [1:0] cmdBits,
  output hostStrobeS stb
);
  logic    secondPending;
  hostCmdE curCmd;

  always_comb begin
    stb = '0;
    if (ctrlWr) begin
      if (!secondPending) begin
        stb.loadLow = 1'b1;
      end else begin
        stb.loadHigh = 1'b1;
        stb.prefetch = (hostCmdE'(cmdBits) == CMD_VRD);
        stb.regWr    = (hostCmdE'(cmdBits) == CMD_REG);
      end
    end
    if (dataRd) begin
      stb.ramRd   = 1'b1;
      stb.dataAdv = 1'b1;
    end
    if (dataWr) begin
      stb.dataAdv = 1'b1;
      stb.palWr   = (curCmd == CMD_PAL);
      stb.ramWr   = (curCmd != CMD_PAL);
    end
    stb.statusRd = ctrlRd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secondPending <= 1'b0;
      curCmd        <= CMD_VRD;
    end else begin
      if (ctrlWr) begin
        secondPending <= !secondPending;
        if (secondPending) curCmd <= hostCmdE'(cmdBits);
      end else if (ctrlRd || dataRd || dataWr) begin
        secondPending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hpData.sv
module hpData
  import hpPkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int VRAM_DEPTH = 4096,
  parameter int PAL_DEPTH  = 32,
  parameter int NUM_REGS   = 11
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  hostStrobeS                stb,
  input  logic [7:0]                wrData,
  input  logic [$clog2(PAL_DEPTH)-1:0] palIdx,
  output logic [7:0]                bufOut,
  output logic [7:0]                palData,
  output logic [NUM_REGS*8-1:0]     modeRegs
);
  localparam int VIDX_W = $clog2(VRAM_DEPTH);
  localparam int PIDX_W = $clog2(PAL_DEPTH);
  localparam int HI_W   = ADDR_W - 8;
  localparam int RSEL_W = 4;

  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] fullAddr;
  logic [VIDX_W-1:0] rdIdx;
  logic [7:0]        vram [VRAM_DEPTH];
  logic [7:0]        pal  [PAL_DEPTH];
  logic [7:0]        ramQ;
  logic [7:0]        readBuf;
  logic              fillPend;
  logic [RSEL_W-1:0] regSel;

  assign fullAddr = {wrData[HI_W-1:0], addr[7:0]};
  assign rdIdx    = stb.loadHigh ? fullAddr[VIDX_W-1:0] : addr[VIDX_W-1:0];
  assign regSel   = wrData[RSEL_W-1:0];

  // Address register: the low byte moves on the first control byte.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr <= '0;
    end else if (stb.loadLow) begin
      addr[7:0] <= wrData;
    end else if (stb.loadHigh) begin
      addr <= stb.prefetch ? fullAddr + ADDR_W'(1) : fullAddr;
    end else if (stb.dataAdv) begin
      addr <= addr + ADDR_W'(1);
    end
  end

  // Video RAM: synchronous array, mirrored across the address space.
  always_ff @(posedge clk) begin
    if (stb.ramWr) vram[addr[VIDX_W-1:0]] <= wrData;
    if (stb.ramRd || stb.prefetch) ramQ <= vram[rdIdx];
  end

  // Read-ahead buffer.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillPend <= 1'b0;
      readBuf  <= '0;
    end else begin
      fillPend <= stb.ramRd || stb.prefetch;
      if (stb.palWr)     readBuf <= wrData;
      else if (fillPend) readBuf <= ramQ;
    end
  end
  assign bufOut = readBuf;

  // Palette RAM.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PAL_DEPTH; i++) pal[i] <= '0;
    end else if (stb.palWr) begin
      pal[addr[PIDX_W-1:0]] <= wrData;
    end
  end
  assign palData = pal[palIdx];

  // Mode registers: data is the low address byte left by the first byte.
  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    logic [7:0] regQ;
    always_ff @(posedge clk) begin
      if (!rstN) regQ <= '0;
      else if (stb.regWr && regSel == RSEL_W'(g)) regQ <= addr[7:0];
    end
    assign modeRegs[g*8 +: 8] = regQ;
  end
endmodule

// File: rtl/hpIrq.sv
module hpIrq #(
  parameter int LINE_W       = 9,
  parameter int ACTIVE_LINES = 192
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineTick,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              sprOvf,
  input  logic              sprCol,
  input  logic              statusRd,
  input  logic              lineIrqEn,
  input  logic              frameIrqEn,
  input  logic [7:0]        reloadVal,
  output logic [7:0]        status,
  output logic              intN
);
  localparam logic [LINE_W-1:0] LAST_COUNTED = LINE_W'(ACTIVE_LINES);

  logic [7:0] lineCnt;
  logic       counting;
  logic       underflow;
  logic       framePend, ovfFlag, colFlag, linePend;

  assign counting  = lineTick && (lineNum <= LAST_COUNTED);
  assign underflow = counting && (lineCnt == 8'h00);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt <= '0;
    end else if (lineTick) begin
      if (!counting || underflow) lineCnt <= reloadVal;
      else                        lineCnt <= lineCnt - 8'd1;
    end
  end

  // Sticky flags: a new event wins over a clearing read.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      framePend <= 1'b0;
      ovfFlag   <= 1'b0;
      colFlag   <= 1'b0;
      linePend  <= 1'b0;
    end else begin
      if (lineTick && lineNum == LAST_COUNTED) framePend <= 1'b1;
      else if (statusRd)                       framePend <= 1'b0;
      if (sprOvf)        ovfFlag <= 1'b1;
      else if (statusRd) ovfFlag <= 1'b0;
      if (sprCol)        colFlag <= 1'b1;
      else if (statusRd) colFlag <= 1'b0;
      if (underflow && lineIrqEn) linePend <= 1'b1;
      else if (statusRd)          linePend <= 1'b0;
    end
  end

  assign status = {framePend, ovfFlag, colFlag, 5'b0};
  assign intN   = !((framePend && frameIrqEn) || linePend);
endmodule

// File: rtl/vdpHostPort.sv
module vdpHostPort
  import hpPkg::*;
#(
  parameter int ADDR_W       = 14,
  parameter int VRAM_DEPTH   = 4096,
  parameter int PAL_DEPTH    = 32,
  parameter int NUM_REGS     = 11,
  parameter int LINE_W       = 9,
  parameter int ACTIVE_LINES = 192
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         ctrlWr,
  input  logic                         ctrlRd,
  input  logic                         dataWr,
  input  logic                         dataRd,
  input  logic [7:0]                   wrData,
  output logic [7:0]                   rdData,
  input  logic                         lineTick,
  input  logic [LINE_W-1:0]            lineNum,
  input  logic                         sprOvf,
  input  logic                         sprCol,
  input  logic [$clog2(PAL_DEPTH)-1:0] palIdx,
  output logic [7:0]                   palData,
  output logic [NUM_REGS*8-1:0]        modeRegs,
  output logic                         intN
);
  localparam int REG_MODE0  = 0;
  localparam int REG_MODE1  = 1;
  localparam int REG_RELOAD = 10;
  localparam int LINE_EN_BIT  = 4;
  localparam int FRAME_EN_BIT = 5;

  hostStrobeS stb;
  logic [7:0] bufOut;
  logic [7:0] status;

  hpCtrl uCtrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlRd(ctrlRd),
    .dataWr(dataWr), .dataRd(dataRd), .cmdBits(wrData[7:6]), .stb(stb)
  );

  hpData #(
    .ADDR_W(ADDR_W), .VRAM_DEPTH(VRAM_DEPTH),
    .PAL_DEPTH(PAL_DEPTH), .NUM_REGS(NUM_REGS)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .palIdx(palIdx),
    .bufOut(bufOut), .palData(palData), .modeRegs(modeRegs)
  );

  hpIrq #(.LINE_W(LINE_W), .ACTIVE_LINES(ACTIVE_LINES)) uIrq (
    .clk(clk), .rstN(rstN), .lineTick(lineTick), .lineNum(lineNum),
    .sprOvf(sprOvf), .sprCol(sprCol), .statusRd(stb.statusRd),
    .lineIrqEn(modeRegs[REG_MODE0*8 + LINE_EN_BIT]),
    .frameIrqEn(modeRegs[REG_MODE1*8 + FRAME_EN_BIT]),
    .reloadVal(modeRegs[REG_RELOAD*8 +: 8]),
    .status(status), .intN(intN)
  );

  assign rdData = ctrlRd ? status : bufOut;
endmodule

// File: rtl/hpHostCheck.sv
module hpHostCheck #(
  parameter int LINE_W       = 9,
  parameter int ACTIVE_LINES = 192,
  parameter int NUM_REGS     = 11,
  parameter int PAL_W        = 5
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  ctrlWr,
  input logic                  ctrlRd,
  input logic                  dataWr,
  input logic                  lineTick,
  input logic [LINE_W-1:0]     lineNum,
  input logic [PAL_W-1:0]      palIdx,
  input logic [7:0]            palData,
  input logic [NUM_REGS*8-1:0] modeRegs,
  input logic                  intN
);
  // R7 / R11: a status read with no new event releases the interrupt.
  a_r7_read_releases_int: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRd && !lineTick && !ctrlWr) |=> intN);

  // R8 / R11: line 192 with frame interrupts enabled asserts intN.
  a_r8_frame_asserts_int: assert property (@(posedge clk) disable iff (!rstN)
    (lineTick && lineNum == LINE_W'(ACTIVE_LINES) && modeRegs[13]) |=> !intN);

  // R11: intN only falls after a line event or a register write.
  a_r11_int_fall_source: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intN) |-> ($past(lineTick) || $past(ctrlWr)));

  // R5: mode registers only change after a control port write.
  a_r5_regs_by_ctrl_only: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modeRegs) |-> $past(ctrlWr));

  // R3: a palette entry only changes through a data port write.
  a_r3_pal_by_data_only: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(palData) |-> ($past(dataWr) || !$stable(palIdx)));
endmodule

bind vdpHostPort hpHostCheck #(
  .LINE_W(LINE_W), .ACTIVE_LINES(ACTIVE_LINES),
  .NUM_REGS(NUM_REGS), .PAL_W($clog2(PAL_DEPTH))
) chk (
  .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlRd(ctrlRd), .dataWr(dataWr),
  .lineTick(lineTick), .lineNum(lineNum), .palIdx(palIdx), .palData(palData),
  .modeRegs(modeRegs), .intN(intN)
);

// File: tb/tb_vdpHostPort.sv
module tb_vdpHostPort;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWr = 1'b0, ctrlRd = 1'b0, dataWr = 1'b0, dataRd = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        lineTick = 1'b0;
  logic [8:0]  lineNum = '0;
  logic        sprOvf = 1'b0, sprCol = 1'b0;
  logic [4:0]  palIdx = '0;
  logic [7:0]  palData;
  logic [87:0] modeRegs;
  logic        intN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vdpHostPort dut (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlRd(ctrlRd),
    .dataWr(dataWr), .dataRd(dataRd), .wrData(wrData), .rdData(rdData),
    .lineTick(lineTick), .lineNum(lineNum), .sprOvf(sprOvf), .sprCol(sprCol),
    .palIdx(palIdx), .palData(palData), .modeRegs(modeRegs), .intN(intN)
  );

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a read strobe is live.
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (dataRd || ctrlRd) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard unexpected read actual=0x%0h expected=none", rdData);
      end else begin
        chk(tagQ.pop_front(), rdData, expQ.pop_front());
      end
    end
  end

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
    @(negedge clk);
  endtask

  task automatic ctrlW(input logic [7:0] b);
    wrData = b; pulse(ctrlWr);
  endtask
  task automatic dataW(input logic [7:0] b);
    wrData = b; pulse(dataWr);
  endtask
  task automatic readD(input logic [7:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag); pulse(dataRd);
  endtask
  task automatic readS(input logic [7:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag); pulse(ctrlRd);
  endtask
  task automatic setAddr(input logic [13:0] a, input logic [1:0] code);
    ctrlW(a[7:0]); ctrlW({code, a[13:8]});
  endtask
  task automatic writeReg(input int idx, input logic [7:0] v);
    ctrlW(v); ctrlW(8'h80 | 8'(idx));
  endtask
  task automatic tick(input int line);
    lineNum = 9'(line); pulse(lineTick);
  endtask
  task automatic chkInt(string tag, logic exp);
    #1 chk(tag, intN, exp);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [87:0] saved;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state (R7, R11, R5)
    readS(8'h00, "R7 reset status");
    chkInt("R11 reset intN", 1'b1);
    chk("R5 reset modeRegs", modeRegs == '0, 1);

    // Write then read back through prefetch (R2, R4)
    setAddr(14'h0100, 2'b01);
    dataW(8'hAA); dataW(8'hBB); dataW(8'hCC);
    setAddr(14'h0100, 2'b00);
    readD(8'hAA, "R2 prefetched first byte");
    readD(8'hBB, "R2 refill second byte");
    readD(8'hCC, "R4 increment third byte");

    // Lone first byte moves low address at once; data write resets toggle (R1, R6)
    setAddr(14'h0200, 2'b01);
    dataW(8'h11);
    ctrlW(8'h40);
    dataW(8'h22);
    setAddr(14'h0240, 2'b00);
    readD(8'h22, "R1 low byte applied immediately");
    setAddr(14'h0200, 2'b00);
    readD(8'h11, "R6 toggle reset by data write");

    // Wrap 0x3FFF -> 0x0000 (R4)
    setAddr(14'h3FFF, 2'b01);
    dataW(8'h5E); dataW(8'h6F);
    setAddr(14'h3FFF, 2'b00);
    readD(8'h5E, "R4 top address");
    readD(8'h6F, "R4 wrapped address");
    setAddr(14'h0000, 2'b00);
    readD(8'h6F, "R4 wrap landed at zero");

    // Register writes (R5)
    writeReg(2, 8'h5A);
    chk("R5 reg2 write", modeRegs[2*8 +: 8], 8'h5A);
    saved = modeRegs;
    writeReg(13, 8'h77);
    chk("R5 reg13 ignored", modeRegs, saved);

    // Palette writes, mask and buffer replacement (R3)
    setAddr(14'h0025, 2'b11);
    dataW(8'h3C); dataW(8'h15);
    palIdx = 5'd5; chkInt("R3 palette entry 5 (intN idle)", 1'b1);
    chk("R3 palette entry 5", palData, 8'h3C);
    palIdx = 5'd6; #1 chk("R3 palette entry 6", palData, 8'h15);
    readD(8'h15, "R3 buffer holds palette write");
    setAddr(14'h003F, 2'b11);
    dataW(8'h2A); dataW(8'h0B);
    palIdx = 5'd31; #1 chk("R3 palette entry 31", palData, 8'h2A);
    palIdx = 5'd0;  #1 chk("R3 palette mask wrap to 0", palData, 8'h0B);

    // Status read and data write reset the toggle (R6)
    ctrlW(8'h34);
    readS(8'h00, "R6 status during half word");
    writeReg(1, 8'h12);
    chk("R6 toggle reset by status read", modeRegs[1*8 +: 8], 8'h12);
    ctrlW(8'h56);
    dataW(8'h00);
    writeReg(3, 8'h21);
    chk("R6 toggle reset by data write", modeRegs[3*8 +: 8], 8'h21);

    // Sticky status flags (R7, R8)
    writeReg(1, 8'h00);
    pulse(sprOvf); pulse(sprCol);
    readS(8'h60, "R7 overflow and collision");
    readS(8'h00, "R7 cleared by one read");
    tick(192);
    chkInt("R11 frame pending but disabled", 1'b1);
    readS(8'h80, "R8 frame pending at line 192");
    readS(8'h00, "R7 frame cleared");

    // Frame interrupt (R8, R11)
    writeReg(1, 8'h20);
    tick(191);
    chkInt("R8 no frame at line 191", 1'b1);
    tick(192);
    chkInt("R8 frame interrupt", 1'b0);
    repeat (5) @(negedge clk);
    chkInt("R11 interrupt held", 1'b0);
    readS(8'h80, "R7 status shows frame");
    chkInt("R11 released by status read", 1'b1);
    writeReg(1, 8'h00);
    tick(192);
    chkInt("R11 pending while disabled", 1'b1);
    writeReg(1, 8'h20);
    chkInt("R11 enable with pending flag", 1'b0);
    readS(8'h80, "R7 status frame again");
    chkInt("R11 released again", 1'b1);

    // Line counter (R9, R11)
    writeReg(1, 8'h00);
    writeReg(10, 8'h02);
    writeReg(0, 8'h10);
    tick(250);
    tick(0); chkInt("R9 count 2->1", 1'b1);
    tick(1); chkInt("R9 count 1->0", 1'b1);
    tick(2); chkInt("R9 underflow interrupt", 1'b0);
    readS(8'h00, "R11 line pending not in status");
    chkInt("R11 line pending cleared", 1'b1);
    tick(3); tick(4);
    chkInt("R9 reloaded count no irq yet", 1'b1);
    tick(5); chkInt("R9 second underflow after reload", 1'b0);
    readS(8'h00, "R11 clear second");

    // Reload write does not touch the running count (R10)
    writeReg(10, 8'h03);
    tick(200);
    tick(0);
    writeReg(10, 8'h00);
    tick(1); chkInt("R10 count continues 1", 1'b1);
    tick(2); chkInt("R10 count continues 0", 1'b1);
    tick(3); chkInt("R10 underflow on old count", 1'b0);
    readS(8'h00, "R10 clear");
    tick(4); chkInt("R10 new reload of zero", 1'b0);
    readS(8'h00, "R10 clear again");

    // Line 193 reloads, does not count (R9)
    writeReg(10, 8'h01);
    tick(193); chkInt("R9 line 193 reloads", 1'b1);
    tick(0);   chkInt("R9 count 1->0 after reload", 1'b1);
    tick(1);   chkInt("R9 underflow after blank reload", 1'b0);
    readS(8'h00, "R9 clear");

    // Line 192 counts; both sources together (R8, R9)
    writeReg(10, 8'h00);
    tick(250);
    tick(192);
    chkInt("R9 line 192 counted and underflows", 1'b0);
    readS(8'h80, "R8 frame set together with line irq");
    chkInt("R11 both cleared", 1'b1);

    // Line interrupt disabled (R9)
    writeReg(0, 8'h00);
    tick(250);
    tick(0); chkInt("R9 underflow with irq disabled", 1'b1);
    writeReg(0, 8'h10);
    chkInt("R9 nothing latched while disabled", 1'b1);

    repeat (4) @(negedge clk);
    chk("scoreboard drained", expQ.size(), 0);
    finishRun();
  end
endmodule